// File: doc/BRIEF.md
# Ramp-compare ADC sequencer

This block is the digital half of a small comparator-based analog-to-digital converter. It drives a reference code onto a resistor ladder and picks an input through the analog mux. It then samples the one-bit comparator answer ("pin voltage is above the reference"). The reference code climbs one level at a time from zero to full scale. The result of a sweep is the highest code at which the comparator said the pin was above the reference. The ladder, the mux and the comparator sit outside the block. They appear here as the `ref_code_o` / `ref_chan_o` outputs and the `cmp_i` input.

There are two modes. The coarse mode converts two pins (channels 0 and 1) to 4 bits each. It sweeps channel 0 and then channel 1 inside one refresh period. The fine mode converts one pin out of four to 6 bits. The lowest-numbered enabled pin is the one converted. One byte-wide control word is written. Reads of the same location return the packed results for the current mode.

The refresh periods are parameters: `REFRESH_CRS` clocks for the coarse mode (default 6144) and `REFRESH_FINE` clocks for the fine mode (default 12288). Each reference level is held for a whole number of clocks derived from them. Both defaults give 192 clocks per level.

Top module: `ramp_adc_seq`

## Requirements
- R1: After reset, and one clock after a write with bit 7 clear, the read value is 0 and `ref_code_o` is 0. While bit 7 is clear, `ref_code_o` stays 0.
- R2: The control word holds these fields. Bit 7 enables the converter. Bit 6 selects the mode: 1 is fine, single pin, 6 bits; 0 is coarse, channels 0 and 1, 4 bits. Bits 3..0 enable pins 3..0. Bits 5..4 have no effect.
- R3: During a sweep, `ref_code_o` counts up by one from 0 to the top level (15 coarse, 63 fine). Each level is held for STEP clocks. STEP is REFRESH_CRS/32 in coarse mode and REFRESH_FINE/64 in fine mode.
- R4: `cmp_i` is sampled on the last clock of each level. A sweep's result is the highest level at which that sample was 1, or 0 if no sample was 1.
- R5: In coarse mode, channel 0 is swept and then channel 1 (`ref_chan_o` = 0 then 1). The channel 0 result changes exactly REFRESH_CRS/2 clocks after a restart. The channel 1 result changes exactly REFRESH_CRS clocks after a restart.
- R6: In coarse mode, if a channel's enable bit is clear, that channel's half-period still elapses with `ref_code_o` at 0, and its result is held.
- R7: In fine mode, the lowest-numbered enabled pin is converted and shown on `ref_chan_o`.
- R8: In fine mode with no pin enabled, conversion is suspended: `ref_code_o` stays 0 and the 6-bit result is held.
- R9: The read value is {channel 1 result, channel 0 result} in coarse mode and {2'b00, 6-bit result} in fine mode.
- R10: Any write restarts the sequence at level 0 on the first channel, discarding the sweep in progress.
- R11: In fine mode, the result changes exactly REFRESH_FINE clocks after a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 8 | Control word |
| rd_data_o | output | 8 | Packed conversion results |
| ref_code_o | output | 6 | Reference ladder level |
| ref_chan_o | output | 2 | Analog mux selection |
| cmp_i | input | 1 | Comparator: 1 when the selected pin is above the reference |

## Verification
A wrong level or step counter shows on `ref_code_o` within one step length. A wrong channel pointer shows on `ref_chan_o` within the same cycle. The bench samples these at the exact clock of each expected change. A wrong peak register or a commit on the wrong edge reaches the ports only through `rd_data_o`, at the end of a sweep. The bench therefore checks the result value one clock before and one clock after each expected update. A held or cleared result that should not have moved is compared after a full refresh period.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

  localparam int CRS_W   = 4;
  localparam int FINE_W  = 6;
  localparam int NUM_PIN = 4;

  typedef struct packed {
    logic                en;
    logic                fine;
    logic [NUM_PIN-1:0]  pin_en;
  } adc_ctrl_t;

  // Lowest-numbered set bit of the pin enable mask, 0 when empty.
  function automatic logic [1:0] first_pin(input logic [NUM_PIN-1:0] m);
    logic [1:0] r;
    r = 2'd0;
    for (int i = NUM_PIN - 1; i >= 0; i--) begin
      if (m[i]) r = 2'(i);
    end
    return r;
  endfunction

  // Read word layout for each mode.
  function automatic logic [7:0] pack_read(input logic fine,
                                           input logic [CRS_W-1:0] r1,
                                           input logic [CRS_W-1:0] r0,
                                           input logic [FINE_W-1:0] rf);
    return fine ? {2'b00, rf} : {r1, r0};
  endfunction

endpackage

// File: rtl/ramp_adc_ctrl_reg.sv
module ramp_adc_ctrl_reg
  import ramp_adc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output adc_ctrl_t  ctrl_o,
  output logic       restart_o
);

  logic unused_bits;
  assign unused_bits = ^wr_data_i[5:4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_o <= '0;
    end else if (wr_en_i) begin
      ctrl_o.en     <= wr_data_i[7];
      ctrl_o.fine   <= wr_data_i[6];
      ctrl_o.pin_en <= wr_data_i[3:0];
    end
  end

  assign restart_o = wr_en_i;

endmodule

// File: rtl/ramp_adc_sweep_timer.sv
module ramp_adc_sweep_timer
  import ramp_adc_pkg::*;
#(
  parameter int STEP_CRS  = 192,
  parameter int STEP_FINE = 192
) (
  input  logic        clk,
  input  logic        rst_n,
  input  adc_ctrl_t   ctrl_i,
  input  logic        restart_i,
  output logic [5:0]  code_o,
  output logic        half_o,
  output logic        step_end_o,
  output logic        sweep_end_o,
  output logic        active_o,
  output logic [1:0]  chan_o
);

  localparam int STEP_MAX = (STEP_CRS > STEP_FINE) ? STEP_CRS : STEP_FINE;
  localparam int SW       = $clog2(STEP_MAX + 1);
  localparam logic [5:0] TOP_CRS  = 6'((1 << CRS_W) - 1);
  localparam logic [5:0] TOP_FINE = 6'((1 << FINE_W) - 1);

  logic [SW-1:0] step_cnt;
  logic [SW-1:0] step_last;
  logic [5:0]    top_code;
  logic          run;

  assign step_last = ctrl_i.fine ? SW'(STEP_FINE - 1) : SW'(STEP_CRS - 1);
  assign top_code  = ctrl_i.fine ? TOP_FINE : TOP_CRS;
  assign run       = ctrl_i.en && (ctrl_i.fine ? (|ctrl_i.pin_en) : 1'b1);

  assign step_end_o  = run && (step_cnt == step_last);
  assign sweep_end_o = step_end_o && (code_o == top_code);
  assign active_o    = run && (ctrl_i.fine ? 1'b1 : ctrl_i.pin_en[{1'b0, half_o}]);
  assign chan_o      = ctrl_i.fine ? first_pin(ctrl_i.pin_en) : {1'b0, half_o};

  always_ff @(posedge clk) begin
    if (!rst_n || restart_i || !run) begin
      step_cnt <= '0;
      code_o   <= '0;
      half_o   <= 1'b0;
    end else if (step_end_o) begin
      step_cnt <= '0;
      if (code_o == top_code) begin
        code_o <= '0;
        if (!ctrl_i.fine) half_o <= ~half_o;
      end else begin
        code_o <= code_o + 6'd1;
      end
    end else begin
      step_cnt <= step_cnt + SW'(1);
    end
  end

  assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_cnt <= step_last);

  assert_code_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_end_o && !sweep_end_o && !restart_i) |=> (code_o == $past(code_o) + 6'd1));

  assert_code_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !step_end_o && !restart_i) |=> $stable(code_o));

  assert_half_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_end_o && !ctrl_i.fine && !restart_i) |=> (half_o != $past(half_o)));

  assert_coarse_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.en && !ctrl_i.fine) |-> (code_o <= TOP_CRS));

endmodule

// File: rtl/ramp_adc_peak_capture.sv
module ramp_adc_peak_capture
  import ramp_adc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  adc_ctrl_t         ctrl_i,
  input  logic              restart_i,
  input  logic              step_end_i,
  input  logic              sweep_end_i,
  input  logic              active_i,
  input  logic              half_i,
  input  logic [5:0]        code_i,
  input  logic              cmp_i,
  output logic [CRS_W-1:0]  res_c0_o,
  output logic [CRS_W-1:0]  res_c1_o,
  output logic [FINE_W-1:0] res_f_o
);

  logic [5:0] best;
  logic [5:0] sweep_best;
  logic       hit_now;
  logic       commit;

  assign hit_now    = step_end_i && active_i && cmp_i;
  assign sweep_best = hit_now ? code_i : best;
  assign commit     = sweep_end_i && active_i && !restart_i;

  always_ff @(posedge clk) begin
    if (!rst_n || restart_i || !ctrl_i.en || sweep_end_i) begin
      best <= '0;
    end else if (hit_now) begin
      best <= code_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !ctrl_i.en) begin
      res_c0_o <= '0;
      res_c1_o <= '0;
      res_f_o  <= '0;
    end else if (commit) begin
      if (ctrl_i.fine)  res_f_o  <= sweep_best;
      else if (half_i)  res_c1_o <= sweep_best[CRS_W-1:0];
      else              res_c0_o <= sweep_best[CRS_W-1:0];
    end
  end

  assert_best_behind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    best <= code_i);

  assert_hold_c0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.en && !commit) |=> ($stable(res_c0_o) && $stable(res_c1_o)));

  assert_hold_fine_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.en && !commit) |=> $stable(res_f_o));

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_i.en |=> (res_c0_o == '0 && res_c1_o == '0 && res_f_o == '0));

endmodule

// File: rtl/ramp_adc_seq.sv
module ramp_adc_seq
  import ramp_adc_pkg::*;
#(
  parameter int REFRESH_CRS  = 6144,
  parameter int REFRESH_FINE = 12288
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic [5:0] ref_code_o,
  output logic [1:0] ref_chan_o,
  input  logic       cmp_i
);

  localparam int STEP_CRS  = REFRESH_CRS / (2 * (1 << CRS_W));
  localparam int STEP_FINE = REFRESH_FINE / (1 << FINE_W);

  adc_ctrl_t         ctrl;
  logic              restart;
  logic [5:0]        code;
  logic              half;
  logic              step_end;
  logic              sweep_end;
  logic              active;
  logic [CRS_W-1:0]  res_c0;
  logic [CRS_W-1:0]  res_c1;
  logic [FINE_W-1:0] res_f;

  ramp_adc_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl),
    .restart_o (restart)
  );

  ramp_adc_sweep_timer #(
    .STEP_CRS  (STEP_CRS),
    .STEP_FINE (STEP_FINE)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_i      (ctrl),
    .restart_i   (restart),
    .code_o      (code),
    .half_o      (half),
    .step_end_o  (step_end),
    .sweep_end_o (sweep_end),
    .active_o    (active),
    .chan_o      (ref_chan_o)
  );

  ramp_adc_peak_capture u_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_i      (ctrl),
    .restart_i   (restart),
    .step_end_i  (step_end),
    .sweep_end_i (sweep_end),
    .active_i    (active),
    .half_i      (half),
    .code_i      (code),
    .cmp_i       (cmp_i),
    .res_c0_o    (res_c0),
    .res_c1_o    (res_c1),
    .res_f_o     (res_f)
  );

  assign ref_code_o = active ? code : 6'd0;
  assign rd_data_o  = pack_read(ctrl.fine, res_c1, res_c0, res_f);

  assert_idle_ref_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |-> (ref_code_o == 6'd0));

  assert_suspend_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && ctrl.fine && ctrl.pin_en == 4'd0) |-> (ref_code_o == 6'd0));

  assert_lowest_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && ctrl.fine && ctrl.pin_en != 4'd0) |->
      (ctrl.pin_en[ref_chan_o] && ((ctrl.pin_en & ((4'd1 << ref_chan_o) - 4'd1)) == 4'd0)));

  assert_coarse_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && !ctrl.fine) |-> (ref_chan_o[1] == 1'b0));

endmodule

// File: tb/ramp_adc_seq_bench.sv
`timescale 1ns/1ps
module ramp_adc_seq_bench;

  localparam int REF_C  = 128;
  localparam int REF_F  = 256;
  localparam int STEP_F = REF_F / 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic [5:0] ref_code;
  logic [1:0] ref_chan;
  logic       cmp;
  logic [7:0] tb_ctrl = 8'd0;
  int         ana [4];
  int         checks = 0;
  int         fails  = 0;
  int         m_r0 = 0, m_r1 = 0, m_rf = 0;

  always #2.5 clk = ~clk;

  // Comparator model: pin level in 1/256 VDD units against ladder level.
  assign cmp = ana[ref_chan] > (int'(ref_code) * (tb_ctrl[6] ? 4 : 16));

  ramp_adc_seq #(.REFRESH_CRS(REF_C), .REFRESH_FINE(REF_F)) u_ramp_adc_seq (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .ref_code_o(ref_code), .ref_chan_o(ref_chan), .cmp_i(cmp)
  );

  // ctrl, a3, a2, a1, a0
  localparam logic [39:0] VEC [8] = '{
    {8'h83, 8'h00, 8'h00, 8'hA0, 8'h30},
    {8'h81, 8'h00, 8'h00, 8'h11, 8'hFF},
    {8'hC4, 8'h00, 8'h81, 8'h00, 8'h00},
    {8'hCA, 8'hF0, 8'h00, 8'h10, 8'hFF},
    {8'hC0, 8'hF0, 8'hF0, 8'hF0, 8'hF0},
    {8'h82, 8'h00, 8'h00, 8'h00, 8'h77},
    {8'hF1, 8'h00, 8'h00, 8'h00, 8'hFF},
    {8'h01, 8'hFF, 8'hFF, 8'hFF, 8'hFF}
  };

  function automatic int conv(input int a, input int levels);
    int r = 0;
    for (int n = 0; n < levels; n++) if (a > n * (256 / levels)) r = n;
    return r;
  endfunction

  function automatic int model_read();
    return tb_ctrl[6] ? m_rf : (m_r1 * 16 + m_r0);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v; tb_ctrl = v;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic update_model();
    if (!tb_ctrl[7]) begin
      m_r0 = 0; m_r1 = 0; m_rf = 0;
    end else if (tb_ctrl[6]) begin
      for (int p = 3; p >= 0; p--) if (tb_ctrl[p]) m_rf = conv(ana[p], 64);
    end else begin
      if (tb_ctrl[0]) m_r0 = conv(ana[0], 16);
      if (tb_ctrl[1]) m_r1 = conv(ana[1], 16);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++) ana[p] = 0;
    edges(3);
    rst_n = 1'b1;
    edges(1);
    chk("R1 reset read", int'(rd_data), 0);
    chk("R1 reset ref", int'(ref_code), 0);

    // Vector table: R2 R4 R6 R7 R8 R9 R1
    for (int v = 0; v < 8; v++) begin
      ana[3] = int'(VEC[v][31:24]); ana[2] = int'(VEC[v][23:16]);
      ana[1] = int'(VEC[v][15:8]);  ana[0] = int'(VEC[v][7:0]);
      do_write(VEC[v][39:32]);
      edges((tb_ctrl[6] ? REF_F : REF_C) * 2 + 8);
      update_model();
      chk($sformatf("R2/R4/R6/R7/R8/R9 vector %0d", v), int'(rd_data), model_read());
      if (!tb_ctrl[7]) chk("R1 disabled ref", int'(ref_code), 0);
    end

    // R3: level timing in fine mode, channel 0
    ana[0] = 200;
    do_write(8'hC1);
    chk("R7 chan", int'(ref_chan), 0);
    edges(STEP_F - 1);
    chk("R3 level held", int'(ref_code), 0);
    edges(1);
    chk("R3 level step", int'(ref_code), 1);
    edges(STEP_F * 4);
    chk("R3 level five", int'(ref_code), 5);

    // R10: write mid-sweep restarts at level 0
    do_write(8'hC1);
    chk("R10 restart ref", int'(ref_code), 0);
    m_rf = conv(200, 64);
    // R11: fine result appears exactly REF_F clocks after restart
    chk("R11 before", int'(rd_data), 0);
    edges(REF_F - 1);
    chk("R11 one clock early", int'(rd_data), 0);
    edges(1);
    chk("R11 at refresh", int'(rd_data), m_rf);

    // R8: suspension holds result and ladder at 0
    do_write(8'hC0);
    edges(STEP_F * 3 + 1);
    chk("R8 suspended ref", int'(ref_code), 0);
    edges(REF_F);
    chk("R8 held result", int'(rd_data), m_rf);

    // R5: coarse channel order and update timing
    ana[0] = 8'h30; ana[1] = 8'hA0;
    do_write(8'h83);
    edges(REF_C * 2 + 4);
    chk("R5 prior value", int'(rd_data), 8'h92);
    ana[0] = 200; ana[1] = 20;
    do_write(8'h83);
    chk("R5 first channel", int'(ref_chan), 0);
    edges(REF_C / 2 - 1);
    chk("R5 ch0 not yet", int'(rd_data), 8'h92);
    edges(1);
    chk("R5 ch0 updated", int'(rd_data), 8'h9C);
    chk("R5 second channel", int'(ref_chan), 1);
    edges(REF_C / 2 - 1);
    chk("R5 ch1 not yet", int'(rd_data), 8'h9C);
    edges(1);
    chk("R5 ch1 updated", int'(rd_data), 8'h1C);

    // R6: disabled channel half keeps ladder at 0
    do_write(8'h81);
    edges(REF_C / 2 + 3);
    chk("R6 idle half ref", int'(ref_code), 0);

    // R1: disable clears results
    do_write(8'h03);
    edges(1);
    chk("R1 cleared", int'(rd_data), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule